// File: doc/BRIEF.md
# Receive Frame Timeout Controller

This block watches a spread-spectrum receiver once PN acquisition has been reached. It decides when the receiver should give up on the current frame and go back to searching. There are two watchdogs. The first bounds the wait for the start-frame delimiter (SFD), measured in symbol strobes against a programmable limit. The second counts received payload bits against the length taken from the header, and ends the frame once that many bits have arrived.

The result is a single-cycle return-to-acquisition pulse. A header that reports a zero length ends the frame as soon as the header completes, and this does not depend on the length-timeout enable. A fresh acquisition pulse restarts supervision from any state, and it always takes priority over an abort in the same cycle.

Top module: `rx_frame_timeout`

## Requirements
- R1: After reset, `reacq` is 0 and the controller is idle. Strobes that arrive before any `acq_pulse` never produce `reacq`.
- R2: After `acq_pulse`, if `sfd_tmr_en` is 1, each `sym_strobe` advances the SFD timer. The strobe that brings the count up to `sfd_limit` causes `reacq` to be 1 in the following cycle, unless an SFD arrives in that same cycle.
- R3: If `sfd_pulse` comes in the same cycle as the strobe that would expire the timer, the SFD is accepted and no `reacq` is issued.
- R4: If `sfd_tmr_en` is 0, no wait for the SFD ever ends in `reacq`, however many symbol strobes arrive.
- R5: In header modes 2 and 3 (`hdr_mode[1]` = 1) with `len_to_en` = 1, the cycle after the `bit_strobe` that brings the received-bit total to `hdr_len` or beyond gives `reacq` = 1.
- R6: A `bit_strobe` with `bit_pair` = 1 adds two bits to the total, and `bit_pair` = 0 adds one. When the total jumps past the length, the frame still ends.
- R7: In modes 2 and 3, a `hdr_done` with `hdr_len` = 0 gives `reacq` in the following cycle, whatever the value of `len_to_en`.
- R8: In modes 0 and 1 (`hdr_mode[1]` = 0), the controller goes idle after the SFD. It then applies no length timeout, and a zero length has no effect.
- R9: If `len_to_en` = 0 and the length is nonzero, the received data bits never cause `reacq`.
- R10: `reacq` lasts exactly one cycle. After it the controller is idle and ignores every strobe until the next `acq_pulse`.
- R11: An `acq_pulse` in any state clears all counters and restarts the SFD wait. No `reacq` follows the cycle of an `acq_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_pulse | input | 1 | PN acquisition achieved |
| sfd_pulse | input | 1 | SFD detected |
| hdr_done | input | 1 | Header complete, `hdr_len` valid |
| hdr_len | input | LEN_W | Payload length in bits |
| sym_strobe | input | 1 | Symbol strobe for the SFD timer |
| bit_strobe | input | 1 | Data bits received this cycle |
| bit_pair | input | 1 | 1: two bits on this strobe, 0: one |
| hdr_mode | input | 2 | Header mode; modes 2 and 3 carry a length |
| sfd_tmr_en | input | 1 | SFD timer enable |
| len_to_en | input | 1 | Length timeout enable |
| sfd_limit | input | TMO_W | SFD timeout in symbol strobes |
| reacq | output | 1 | Return-to-acquisition pulse |

## Verification
Several properties are checked on every cycle. `reacq` never lasts two cycles and always leaves the controller idle. An acquisition pulse always suppresses the abort in the cycle that follows. An SFD that arrives with no other trigger present cancels any abort. A disabled SFD timer never aborts, and a zero-length header always does. The exact cycle on which each counter ends, the counting of two bits per strobe with overshoot, the header-mode gating and the restart partway through a count depend on sequences of stimulus. Only the directed scenarios in the bench can show these.

// File: rtl/rx_frame_timeout.sv
module rx_frame_timeout #(
  parameter int LEN_W = 16,
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_pulse,
  input  logic             sfd_pulse,
  input  logic             hdr_done,
  input  logic [LEN_W-1:0] hdr_len,
  input  logic             sym_strobe,
  input  logic             bit_strobe,
  input  logic             bit_pair,
  input  logic [1:0]       hdr_mode,
  input  logic             sfd_tmr_en,
  input  logic             len_to_en,
  input  logic [TMO_W-1:0] sfd_limit,
  output logic             reacq
);
  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_SFD  = 2'd1;
  localparam logic [1:0] S_HDR  = 2'd2;
  localparam logic [1:0] S_DATA = 2'd3;
  localparam int BW = LEN_W + 1;
  localparam int TW = TMO_W + 1;

  logic [1:0]       state;
  logic [TMO_W-1:0] tcnt;
  logic [LEN_W-1:0] len_q;
  logic [BW-1:0]    bcnt;

  wire          has_len = hdr_mode[1];
  wire [TW-1:0] tnext   = {1'b0, tcnt} + TW'(1);
  wire [BW-1:0] bnext   = bcnt + (bit_pair ? BW'(2) : BW'(1));

  wire sfd_expire = (state == S_SFD) && sfd_tmr_en && sym_strobe && !sfd_pulse &&
                    (tnext >= {1'b0, sfd_limit});
  wire len_done   = (state == S_DATA) && bit_strobe && (bnext >= {1'b0, len_q});
  wire zero_len   = (state == S_HDR) && hdr_done && (hdr_len == '0);
  wire abort      = !acq_pulse && (sfd_expire || len_done || zero_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      tcnt  <= '0;
      bcnt  <= '0;
      len_q <= '0;
      reacq <= 1'b0;
    end else begin
      reacq <= abort;
      if (acq_pulse) begin
        state <= S_SFD;
        tcnt  <= '0;
        bcnt  <= '0;
      end else if (abort) begin
        state <= S_IDLE;
        tcnt  <= '0;
        bcnt  <= '0;
      end else begin
        case (state)
          S_SFD: begin
            if (sfd_pulse) begin
              state <= has_len ? S_HDR : S_IDLE;
              tcnt  <= '0;
            end else if (sfd_tmr_en && sym_strobe) begin
              tcnt <= tnext[TMO_W-1:0];
            end
          end
          S_HDR: begin
            if (hdr_done) begin
              if (len_to_en) begin
                len_q <= hdr_len;
                bcnt  <= '0;
                state <= S_DATA;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_DATA: begin
            if (bit_strobe) bcnt <= bnext;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module rx_frame_timeout_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acq_pulse,
  input logic             sfd_pulse,
  input logic             hdr_done,
  input logic [LEN_W-1:0] hdr_len,
  input logic             bit_strobe,
  input logic             sfd_tmr_en,
  input logic [1:0]       st,
  input logic             reacq
);
  AST_REACQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) reacq |=> !reacq); // R10
  AST_REACQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n) reacq |-> st == 2'd0); // R10
  AST_ACQ_WINS: assert property (@(posedge clk) disable iff (!rst_n) acq_pulse |=> !reacq); // R11
  AST_SFD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && sfd_pulse && !hdr_done && !bit_strobe) |=> !reacq); // R3
  AST_TMR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && !sfd_tmr_en) |=> !reacq); // R4
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && hdr_done && hdr_len == '0 && !acq_pulse) |=> reacq); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |=> !reacq); // R1
endmodule

bind rx_frame_timeout rx_frame_timeout_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acq_pulse(acq_pulse), .sfd_pulse(sfd_pulse),
  .hdr_done(hdr_done), .hdr_len(hdr_len), .bit_strobe(bit_strobe),
  .sfd_tmr_en(sfd_tmr_en), .st(state), .reacq(reacq)
);

// File: tb/rx_frame_timeout_tb.sv
module rx_frame_timeout_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq = 0, sfd = 0, hdr = 0, sym = 0, bs = 0, pr = 0;
  logic [15:0] len = '0;
  logic [1:0] mode = 2'd2;
  logic tmr_en = 1'b1, len_en = 1'b1;
  logic [7:0] limit = 8'd3;
  logic reacq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_frame_timeout u_dut (
    .clk(clk), .rst_n(rst_n), .acq_pulse(acq), .sfd_pulse(sfd), .hdr_done(hdr),
    .hdr_len(len), .sym_strobe(sym), .bit_strobe(bs), .bit_pair(pr),
    .hdr_mode(mode), .sfd_tmr_en(tmr_en), .len_to_en(len_en),
    .sfd_limit(limit), .reacq(reacq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s reacq actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic a, input logic s, input logic h, input logic [15:0] l,
                     input logic y, input logic b, input logic p, output logic r);
    @(negedge clk);
    acq = a; sfd = s; hdr = h; len = l; sym = y; bs = b; pr = p;
    @(posedge clk);
    #1;
    r = reacq;
    acq = 0; sfd = 0; hdr = 0; sym = 0; bs = 0; pr = 0;
  endtask

  task automatic t_reset();
    logic r;
    chk("R1 reset", reacq, 1'b0);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 0, 16'd0, 1, 1, 0, r);
      chk("R1 no acq", r, 1'b0);
    end
  endtask

  task automatic t_sfd_expire();
    logic r;
    tmr_en = 1; limit = 8'd3;
    cyc(1, 0, 0, 0, 0, 0, 0, r); chk("R11 acq", r, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, r); chk("R2 strobe1", r, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, r); chk("R2 gap", r, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, r); chk("R2 strobe2", r, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, r); chk("R2 expire", r, 1);
    cyc(0, 0, 0, 0, 1, 0, 0, r); chk("R10 one cycle", r, 0);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 0, 0, 1, 1, 1, r); chk("R10 idle", r, 0);
    end
  endtask

  task automatic t_sfd_tie();
    logic r;
    limit = 8'd2; mode = 2'd0;
    cyc(1, 0, 0, 0, 0, 0, 0, r);
    cyc(0, 0, 0, 0, 1, 0, 0, r); chk("R3 pre", r, 0);
    cyc(0, 1, 0, 0, 1, 0, 0, r); chk("R3 tie", r, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, r); chk("R3 after", r, 0);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 1, 16'd0, 1, 1, 1, r); chk("R8 mode0 idle", r, 0);
    end
  endtask

  task automatic t_tmr_off();
    logic r;
    tmr_en = 0; limit = 8'd1;
    cyc(1, 0, 0, 0, 0, 0, 0, r);
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0, 0, 0, 1, 0, 0, r); chk("R4 disabled", r, 0);
    end
    tmr_en = 1;
  endtask

  task automatic t_len_single();
    logic r;
    mode = 2'd2; len_en = 1; limit = 8'd50;
    cyc(1, 0, 0, 0, 0, 0, 0, r);
    cyc(0, 1, 0, 0, 0, 0, 0, r);
    cyc(0, 0, 1, 16'd5, 0, 0, 0, r); chk("R5 hdr", r, 0);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0, 0, 0, 1, 0, r); chk("R5 counting", r, 0);
    end
    cyc(0, 0, 0, 0, 0, 1, 0, r); chk("R5 end", r, 1);
    cyc(0, 0, 0, 0, 0, 1, 0, r); chk("R10 after len", r, 0);
  endtask

  task automatic t_len_pair();
    logic r;
    mode = 2'd3; len_en = 1;
    cyc(1, 0, 0, 0, 0, 0, 0, r);
    cyc(0, 1, 0, 0, 0, 0, 0, r);
    cyc(0, 0, 1, 16'd5, 0, 0, 0, r);
    cyc(0, 0, 0, 0, 0, 1, 1, r); chk("R6 two", r, 0);
    cyc(0, 0, 0, 0, 0, 1, 1, r); chk("R6 four", r, 0);
    cyc(0, 0, 0, 0, 0, 1, 1, r); chk("R6 overshoot", r, 1);
  endtask

  task automatic t_zero_len();
    logic r;
    mode = 2'd2; len_en = 0;
    cyc(1, 0, 0, 0, 0, 0, 0, r);
    cyc(0, 1, 0, 0, 0, 0, 0, r);
    cyc(0, 0, 1, 16'd0, 0, 0, 0, r); chk("R7 zero len", r, 1);
    len_en = 1;
  endtask

  task automatic t_len_off();
    logic r;
    mode = 2'd3; len_en = 0;
    cyc(1, 0, 0, 0, 0, 0, 0, r);
    cyc(0, 1, 0, 0, 0, 0, 0, r);
    cyc(0, 0, 1, 16'd3, 0, 0, 0, r);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 0, 0, 0, 1, 0, r); chk("R9 len off", r, 0);
    end
    len_en = 1;
  endtask

  task automatic t_mode1();
    logic r;
    mode = 2'd1; len_en = 1;
    cyc(1, 0, 0, 0, 0, 0, 0, r);
    cyc(0, 1, 0, 0, 0, 0, 0, r);
    cyc(0, 0, 1, 16'd0, 0, 0, 0, r); chk("R8 mode1 zero", r, 0);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 0, 0, 0, 1, 1, r); chk("R8 mode1 bits", r, 0);
    end
  endtask

  task automatic t_restart();
    logic r;
    mode = 2'd2; limit = 8'd3; tmr_en = 1;
    cyc(1, 0, 0, 0, 0, 0, 0, r);
    cyc(0, 0, 0, 0, 1, 0, 0, r);
    cyc(0, 0, 0, 0, 1, 0, 0, r);
    cyc(1, 0, 0, 0, 1, 0, 0, r); chk("R11 acq on expiry", r, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, r); chk("R11 cleared 1", r, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, r); chk("R11 cleared 2", r, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, r); chk("R11 re-expire", r, 1);
    cyc(1, 0, 0, 0, 0, 0, 0, r);
    cyc(0, 1, 0, 0, 0, 0, 0, r);
    cyc(0, 0, 1, 16'd2, 0, 0, 0, r);
    cyc(0, 0, 0, 0, 0, 1, 0, r);
    cyc(1, 0, 0, 0, 0, 1, 0, r); chk("R11 acq in data", r, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, r); chk("R11 data dropped", r, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, r); chk("R11 data dropped 2", r, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_sfd_expire();
    t_sfd_tie();
    t_tmr_off();
    t_len_single();
    t_len_pair();
    t_zero_len();
    t_len_off();
    t_mode1();
    t_restart();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule